// File: doc/BRIEF.md
# Configurable Control-Pin and Clock-Output Manager

This block sits between the pads of a spread-spectrum clock generator and its clock core. Four pin slots carry asynchronous control levels. A static configuration word gives each slot one role: output enable, active-low power-down, spread enable or divider select. The two upper slots can also be used as outputs instead of inputs. The block synchronises the pin levels and works out the effective value of each control function. Any function that no legal pin carries falls back to a default.

The block divides the VCO clock by one of two programmable integer ratios. A change of ratio takes effect only on the terminal count of the running divider, so the output never shows a short pulse. The block drives six clock outputs, each with its own pad enable. Four outputs always carry the divided clock. The other two follow the mode of their slot: divided clock, buffered reference, or tri-stated when the slot is a control input.

After power-down is released, the outputs stay tri-stated until a programmable settle count has run out. Bad configurations raise an error output and do not take effect.

Top module: `clkpin_mgr`

## Requirements
- R1: Role code per slot s in `cfg_role[3s+2:3s]`: 0 none, 1 output enable, 2 power-down (active low), 3 spread enable, 4 divider select, 5 to 7 reserved. Slots 0 and 1 are always control inputs. Slot 2 (mode `cfg_mf_mode[1:0]`) and slot 3 (mode `cfg_mf_mode[3:2]`) are control inputs only in mode 2. Any other mode ignores their role code. A reserved code on a control slot sets `cfg_err` and has no effect.
- R2: Power-down placed on slot 2 or 3 sets `cfg_err`, and that pin has no effect.
- R3: A role placed on more than one control slot sets `cfg_err`, and none of those slots controls that role.
- R4: A role that no legal slot carries takes its default: outputs enabled, powered up, spread on, select 0.
- R5: Each pin passes through two flops. A level driven before edge k reaches the outputs after edge k+1 and not before.
- R6: With the effective enable at 0, all six `clk_oe` and `clk_out` bits are 0. With it at 1 and the block running, the four fixed outputs have `clk_oe`=1.
- R7: With the effective power-down at 0, `low_power`=1 and all outputs are tri-stated (`clk_oe`=0, `clk_out`=0).
- R8: Once the synchronised power-down level rises, `low_power` drops one edge later. The outputs are enabled after a further `cfg_settle`+1 edges. Reset starts the same count.
- R9: Each divider runs with period N clocks and stays high for (N+1)/2 of them. N is its ratio clamped to 2..130. A ratio outside that range sets `cfg_err`.
- R10: Select 0 picks `cfg_div_a` and select 1 picks `cfg_div_b`. `div_sel` changes only on the active divider's terminal count, so every output period is a full period of one divider.
- R11: Outputs 5 and 6 (`clk_out[4]`, `clk_out[5]`) follow their slot's mode: 0 divided clock, 1 gated copy of `ref_in`, 2 tri-stated. Mode 3 is tri-stated and sets `cfg_err`.
- R12: `spread_en` gives the effective spread-enable level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_role | input | 12 | Role code per slot, 3 bits each |
| cfg_mf_mode | input | 4 | Mode of slots 2 and 3, 2 bits each |
| cfg_div_a | input | 8 | Ratio used with select 0 |
| cfg_div_b | input | 8 | Ratio used with select 1 |
| cfg_settle | input | 16 | Settle count after power-up |
| pin_in | input | 4 | Asynchronous pin levels, one per slot |
| ref_in | input | 1 | Reference clock to buffer |
| clk_out | output | 6 | Clock output levels |
| clk_oe | output | 6 | Pad drive enables, 0 means tri-state |
| spread_en | output | 1 | Effective spread enable |
| div_sel | output | 1 | Divider in use |
| low_power | output | 1 | Powered-down indication |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
On every cycle the assertions check the following:
- all outputs stay quiet while powered down;
- no output is driven in the cycle that power-down is released, or at any time the block is not running;
- the four fixed enables always agree;
- the divider select changes only on a terminal count;
- power-down on slot 2 always flags an error;
- a slot-2 input leaves output 5 tri-stated.

Only the bench scenarios can show the rest:
- the exact synchroniser and settle latencies;
- the measured divider periods and duty;
- the absence of off-ratio periods while the select toggles;
- the duplicate-role and default rules, checked against a model over random configurations.

// File: rtl/clkpin_pkg.sv
package clkpin_pkg;
  localparam int NSLOT     = 4;
  localparam int NFIX_CTL  = 2;
  localparam int NMF       = NSLOT - NFIX_CTL;
  localparam int NROLE     = 4;
  localparam int NOUT      = 6;
  localparam int NFIX_OUT  = NOUT - NMF;
  localparam int ROLE_W    = 3;
  localparam int MODE_W    = 2;
  localparam int DIV_MIN   = 2;
  localparam int DIV_MAX   = 130;

  // role indices inside the decoded vectors
  localparam int RI_OE  = 0;
  localparam int RI_PDN = 1;
  localparam int RI_SS  = 2;
  localparam int RI_SEL = 3;
  localparam logic [NROLE-1:0] ROLE_DEFAULT = 4'b0111;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_NONE = 3'd0,
    ROLE_OE   = 3'd1,
    ROLE_PDN  = 3'd2,
    ROLE_SS   = 3'd3,
    ROLE_SEL  = 3'd4
  } role_e;

  typedef enum logic [MODE_W-1:0] {
    MF_SPREAD = 2'd0,
    MF_REF    = 2'd1,
    MF_INPUT  = 2'd2,
    MF_RSVD   = 2'd3
  } mfmode_e;

  typedef enum logic [1:0] {
    PWR_DOWN = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_UP   = 2'd2
  } pwr_e;

  function automatic int unsigned clamp_div(input int unsigned v);
    if (v < DIV_MIN) return DIV_MIN;
    if (v > DIV_MAX) return DIV_MAX;
    return v;
  endfunction

  function automatic logic div_out_of_range(input int unsigned v);
    return (v < DIV_MIN) || (v > DIV_MAX);
  endfunction

  // number of high cycles in one period of ratio n
  function automatic int unsigned high_len(input int unsigned n);
    return (n + 1) / 2;
  endfunction

  function automatic logic slot_may_hold(input int slot, input logic [ROLE_W-1:0] code);
    if (code == ROLE_PDN) return slot < NFIX_CTL;
    return (code == ROLE_OE) || (code == ROLE_SS) || (code == ROLE_SEL);
  endfunction
endpackage

// File: rtl/clkpin_sync.sv
module clkpin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;
endmodule

// File: rtl/clkpin_role_decode.sv
module clkpin_role_decode import clkpin_pkg::*; (
  input  logic [NSLOT*ROLE_W-1:0]        cfg_role,
  input  logic [NMF*MODE_W-1:0]          cfg_mf_mode,
  output logic [NROLE-1:0][NSLOT-1:0]    owner,
  output logic                           role_err
);
  logic [NSLOT*MODE_W-1:0]       mode_all;
  logic [NROLE-1:0][NSLOT-1:0]   cand;
  logic [NSLOT-1:0]              slot_ctl;
  logic                          bad_code;
  logic                          dup;

  // fixed slots behave as if their mode were "control input"
  assign mode_all = {cfg_mf_mode, {NFIX_CTL{MF_INPUT}}};

  always_comb begin
    cand     = '0;
    bad_code = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      logic [ROLE_W-1:0] code;
      logic [MODE_W-1:0] mode;
      code = cfg_role[s*ROLE_W +: ROLE_W];
      mode = mode_all[s*MODE_W +: MODE_W];
      slot_ctl[s] = (mode == MF_INPUT);
      if (mode == MF_RSVD) bad_code = 1'b1;
      if (slot_ctl[s] && (code != ROLE_NONE)) begin
        if (!slot_may_hold(s, code)) begin
          bad_code = 1'b1;
        end else begin
          case (role_e'(code))
            ROLE_OE:  cand[RI_OE][s]  = 1'b1;
            ROLE_PDN: cand[RI_PDN][s] = 1'b1;
            ROLE_SS:  cand[RI_SS][s]  = 1'b1;
            ROLE_SEL: cand[RI_SEL][s] = 1'b1;
            default:  bad_code = 1'b1;
          endcase
        end
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int r = 0; r < NROLE; r++) begin
      if ($countones(cand[r]) > 1) begin
        dup      = 1'b1;
        owner[r] = '0;
      end else begin
        owner[r] = cand[r];
      end
    end
  end

  assign role_err = bad_code | dup;
endmodule

// File: rtl/clkpin_div.sv
module clkpin_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  input  logic             restart,
  output logic             clk_q,
  output logic             tc
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W:0]   hi_len;

  assign tc      = (cnt >= ratio - 1'b1);
  assign cnt_nxt = (restart || tc) ? '0 : cnt + 1'b1;
  assign hi_len  = (DIV_W+1)'(clkpin_pkg::high_len(32'(ratio)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      clk_q <= ({1'b0, cnt_nxt} < hi_len);
    end
  end
endmodule

// File: rtl/clkpin_power.sv
module clkpin_power import clkpin_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [CNT_W-1:0] settle,
  output logic             running,
  output logic             low_power
);
  pwr_e             state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PWR_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        PWR_DOWN: if (pd_n) begin
          state <= PWR_WAIT;
          cnt   <= '0;
        end
        PWR_WAIT: begin
          if (!pd_n)              state <= PWR_DOWN;
          else if (cnt >= settle) state <= PWR_UP;
          else                    cnt   <= cnt + 1'b1;
        end
        PWR_UP:  if (!pd_n) state <= PWR_DOWN;
        default: state <= PWR_DOWN;
      endcase
    end
  end

  assign running   = (state == PWR_UP);
  assign low_power = (state == PWR_DOWN);
endmodule

// File: rtl/clkpin_mgr.sv
module clkpin_mgr import clkpin_pkg::*; #(
  parameter int DIV_W    = 8,
  parameter int SETTLE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT*ROLE_W-1:0]  cfg_role,
  input  logic [NMF*MODE_W-1:0]    cfg_mf_mode,
  input  logic [DIV_W-1:0]         cfg_div_a,
  input  logic [DIV_W-1:0]         cfg_div_b,
  input  logic [SETTLE_W-1:0]      cfg_settle,
  input  logic [NSLOT-1:0]         pin_in,
  input  logic                     ref_in,
  output logic [NOUT-1:0]          clk_out,
  output logic [NOUT-1:0]          clk_oe,
  output logic                     spread_en,
  output logic                     div_sel,
  output logic                     low_power,
  output logic                     cfg_err
);
  localparam int NDIV = 2;

  logic [NSLOT-1:0]              pin_sync;
  logic [NROLE-1:0][NSLOT-1:0]   owner;
  logic                          role_err;
  logic [NROLE-1:0]              role_has;
  logic [NROLE-1:0]              role_lvl;
  logic [NROLE-1:0]              ctl_eff;

  logic [NDIV-1:0][DIV_W-1:0]    div_raw;
  logic [NDIV-1:0][DIV_W-1:0]    div_eff;
  logic [NDIV-1:0]               div_bad;
  logic [NDIV-1:0]               div_q;
  logic [NDIV-1:0]               div_tc;
  logic [NDIV-1:0]               restart;

  logic act_sel;
  logic sel_req;
  logic tc_active;
  logic sel_switch;
  logic div_clk;
  logic pwr_running;
  logic drive_en;

  clkpin_sync #(.W(NSLOT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  clkpin_role_decode u_dec (
    .cfg_role    (cfg_role),
    .cfg_mf_mode (cfg_mf_mode),
    .owner       (owner),
    .role_err    (role_err)
  );

  for (genvar r = 0; r < NROLE; r++) begin : g_role
    assign role_has[r] = |owner[r];
    assign role_lvl[r] = |(owner[r] & pin_sync);
    assign ctl_eff[r]  = role_has[r] ? role_lvl[r] : ROLE_DEFAULT[r];
  end

  assign sel_req   = ctl_eff[RI_SEL];
  assign spread_en = ctl_eff[RI_SS];
  assign div_raw   = {cfg_div_b, cfg_div_a};

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    assign div_eff[k] = DIV_W'(clamp_div(32'(div_raw[k])));
    assign div_bad[k] = div_out_of_range(32'(div_raw[k]));
    assign restart[k] = sel_switch && (sel_req == (k == 1));

    clkpin_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio   (div_eff[k]),
      .restart (restart[k]),
      .clk_q   (div_q[k]),
      .tc      (div_tc[k])
    );
  end

  assign tc_active  = act_sel ? div_tc[1] : div_tc[0];
  assign sel_switch = tc_active && (sel_req != act_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_sel <= 1'b0;
    else if (sel_switch) act_sel <= sel_req;
  end

  assign div_clk = act_sel ? div_q[1] : div_q[0];
  assign div_sel = act_sel;

  clkpin_power #(.CNT_W(SETTLE_W)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (ctl_eff[RI_PDN]),
    .settle    (cfg_settle),
    .running   (pwr_running),
    .low_power (low_power)
  );

  assign drive_en = pwr_running & ctl_eff[RI_OE];

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    if (i < NFIX_OUT) begin : g_fixed
      assign clk_oe[i]  = drive_en;
      assign clk_out[i] = drive_en & div_clk;
    end else begin : g_multi
      mfmode_e mode;
      assign mode = mfmode_e'(cfg_mf_mode[(i-NFIX_OUT)*MODE_W +: MODE_W]);
      always_comb begin
        case (mode)
          MF_SPREAD: begin
            clk_oe[i]  = drive_en;
            clk_out[i] = drive_en & div_clk;
          end
          MF_REF: begin
            clk_oe[i]  = drive_en;
            clk_out[i] = drive_en & ref_in;
          end
          default: begin
            clk_oe[i]  = 1'b0;
            clk_out[i] = 1'b0;
          end
        endcase
      end
    end
  end

  assign cfg_err = role_err | (|div_bad);
endmodule

// File: rtl/clkpin_mgr_chk.sv
module clkpin_mgr_chk import clkpin_pkg::*; (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSLOT*ROLE_W-1:0] cfg_role,
  input logic [NMF*MODE_W-1:0]   cfg_mf_mode,
  input logic [NOUT-1:0]         clk_oe,
  input logic [NOUT-1:0]         clk_out,
  input logic                    low_power,
  input logic                    cfg_err,
  input logic                    div_sel,
  input logic                    tc_active,
  input logic                    pwr_running
);
  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (clk_oe == '0) && (clk_out == '0));

  p_settle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_power) |-> (clk_oe == '0));

  p_drive_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_oe) |-> pwr_running);

  p_fixed_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe[NFIX_OUT-1:0] == '0) || (&clk_oe[NFIX_OUT-1:0]));

  p_sel_at_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(tc_active));

  p_pd_slot_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mf_mode[MODE_W-1:0] == MF_INPUT &&
     cfg_role[NFIX_CTL*ROLE_W +: ROLE_W] == ROLE_PDN) |-> cfg_err);

  p_input_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mf_mode[MODE_W-1:0] == MF_INPUT) |-> !clk_oe[NFIX_OUT] && !clk_out[NFIX_OUT]);
endmodule

bind clkpin_mgr clkpin_mgr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_role    (cfg_role),
  .cfg_mf_mode (cfg_mf_mode),
  .clk_oe      (clk_oe),
  .clk_out     (clk_out),
  .low_power   (low_power),
  .cfg_err     (cfg_err),
  .div_sel     (div_sel),
  .tc_active   (tc_active),
  .pwr_running (pwr_running)
);

// File: tb/test_clkpin_mgr.sv
`timescale 1ns/1ps
module test_clkpin_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_role = '0;
  logic [3:0]  cfg_mf_mode = '0;
  logic [7:0]  cfg_div_a = 8'd4;
  logic [7:0]  cfg_div_b = 8'd8;
  logic [15:0] cfg_settle = 16'd5;
  logic [3:0]  pin_in = '0;
  logic        ref_in = 1'b0;
  logic [5:0]  clk_out, clk_oe;
  logic        spread_en, div_sel, low_power, cfg_err;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkpin_mgr i_clkpin_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role), .cfg_mf_mode(cfg_mf_mode),
    .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b), .cfg_settle(cfg_settle),
    .pin_in(pin_in), .ref_in(ref_in), .clk_out(clk_out), .clk_oe(clk_oe),
    .spread_en(spread_en), .div_sel(div_sel), .low_power(low_power), .cfg_err(cfg_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] roles(input int r0, r1, r2, r3);
    return {3'(r3), 3'(r2), 3'(r1), 3'(r0)};
  endfunction

  // independent model of the pin-role rules
  function automatic void model(input logic [11:0] rl, input logic [3:0] md,
                                input logic [3:0] pins, output bit err,
                                output bit oe, output bit pdn, output bit ss, output bit sel);
    int cnt[5];
    int who[5];
    err = 0;
    for (int c = 0; c < 5; c++) begin cnt[c] = 0; who[c] = 0; end
    for (int s = 0; s < 4; s++) begin
      int code;
      int mode;
      code = int'(rl[3*s +: 3]);
      mode = (s == 2) ? int'(md[1:0]) : (s == 3) ? int'(md[3:2]) : 2;
      if (mode == 3) err = 1;
      if (mode == 2 && code != 0) begin
        if (code > 4 || (code == 2 && s >= 2)) err = 1;
        else begin cnt[code]++; who[code] = s; end
      end
    end
    for (int c = 1; c < 5; c++) if (cnt[c] > 1) err = 1;
    oe  = (cnt[1] == 1) ? pins[who[1]] : 1'b1;
    pdn = (cnt[2] == 1) ? pins[who[2]] : 1'b1;
    ss  = (cnt[3] == 1) ? pins[who[3]] : 1'b1;
    sel = (cnt[4] == 1) ? pins[who[4]] : 1'b0;
  endfunction

  task automatic measure(input int idx, output int per, output int hi);
    bit prev, cur, rise;
    int guard = 0;
    per = 0; hi = 0;
    @(negedge clk); prev = clk_out[idx];
    do begin
      @(negedge clk); cur = clk_out[idx]; rise = !prev && cur; prev = cur; guard++;
    end while (!rise && guard < 400);
    hi = 1;
    do begin
      @(negedge clk); cur = clk_out[idx]; rise = !prev && cur; prev = cur;
      per++; guard++;
      if (cur && !rise) hi++;
    end while (!rise && guard < 800);
  endtask

  // period monitor for the select-toggle scenario
  bit mon_en = 0, mon_seen = 0, mon_prev = 0;
  int mon_len = 0, mon_bad = 0, mon_per = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_seen = 0; mon_len = 0; mon_prev = 0;
    end else begin
      if (clk_out[0] && !mon_prev) begin
        if (mon_seen) begin
          mon_per++;
          if (mon_len != 3 && mon_len != 7) mon_bad++;
        end
        mon_seen = 1; mon_len = 1;
      end else if (mon_seen) mon_len++;
      mon_prev = clk_out[0];
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      summary();
      $finish;
    end
  end

  initial begin
    int per, hi;
    bit e_err, e_oe, e_pdn, e_ss, e_sel;
    void'($urandom(32'h1c5e_2024));

    // reset state
    step(3);
    chk("R8 reset tri-state", int'(clk_oe), 0);
    rst_n = 1'b1;
    step(1);
    chk("R8 no low_power after reset", int'(low_power), 0);
    chk("R10 div_sel after reset", int'(div_sel), 0);
    chk("R1 cfg_err clean", int'(cfg_err), 0);
    chk("R12 R4 spread default", int'(spread_en), 1);
    step(20);
    chk("R4 R6 default outputs driven", int'(clk_oe), 6'h3F);

    // R9 divider periods and duty
    begin
      int ratios[6] = '{4, 5, 2, 130, 1, 200};
      int expn[6]   = '{4, 5, 2, 130, 2, 130};
      for (int t = 0; t < 6; t++) begin
        cfg_div_a = 8'(ratios[t]);
        step(300);
        measure(0, per, hi);
        chk($sformatf("R9 period ratio %0d", ratios[t]), per, expn[t]);
        chk($sformatf("R9 high ratio %0d", ratios[t]), hi, (expn[t] + 1) / 2);
        chk($sformatf("R9 cfg_err ratio %0d", ratios[t]), int'(cfg_err),
            (ratios[t] < 2 || ratios[t] > 130) ? 1 : 0);
      end
    end

    // R10 select between dividers
    cfg_div_a = 8'd3; cfg_div_b = 8'd7;
    cfg_role = roles(0, 4, 0, 0);
    pin_in = 4'b0000;
    step(40);
    measure(0, per, hi);
    chk("R10 select 0 uses div a", per, 3);
    pin_in = 4'b0010;
    step(40);
    chk("R10 div_sel follows select", int'(div_sel), 1);
    measure(0, per, hi);
    chk("R10 select 1 uses div b", per, 7);
    mon_en = 1;
    for (int t = 0; t < 30; t++) begin
      pin_in[1] = ~pin_in[1];
      step(1 + int'($urandom % 25));
    end
    step(20);
    mon_en = 0;
    chk("R10 no off-ratio period while toggling", mon_bad, 0);
    chk("R10 periods observed", int'(mon_per > 20), 1);

    // R5 / R6 output enable through synchroniser
    cfg_role = roles(1, 0, 0, 0);
    pin_in = 4'b0001;
    step(20);
    chk("R6 enabled", int'(clk_oe), 6'h3F);
    pin_in[0] = 1'b0;
    step(1);
    chk("R5 still driven after one edge", int'(clk_oe), 6'h3F);
    step(1);
    chk("R5 R6 disabled after two edges", int'(clk_oe), 0);
    chk("R6 outputs low when disabled", int'(clk_out), 0);
    pin_in[0] = 1'b1;
    step(5);

    // R7 / R8 power-down and settle
    cfg_role = roles(2, 1, 0, 0);
    cfg_settle = 16'd5;
    pin_in = 4'b0011;
    step(30);
    pin_in[0] = 1'b0;
    step(3);
    chk("R7 low_power asserted", int'(low_power), 1);
    chk("R7 outputs tri-stated", int'(clk_oe), 0);
    step(10);
    pin_in[0] = 1'b1;
    step(3);
    chk("R8 low_power released", int'(low_power), 0);
    step(5);
    chk("R8 still held before settle", int'(clk_oe), 0);
    step(1);
    chk("R8 driven after settle", int'(clk_oe), 6'h3F);

    // R11 multi-function modes
    cfg_role = '0;
    cfg_mf_mode = 4'b0000;
    step(10);
    begin
      int mism = 0;
      for (int t = 0; t < 12; t++) begin
        step(1);
        if (clk_out[4] != clk_out[0] || clk_out[5] != clk_out[0]) mism++;
      end
      chk("R11 spread mode mirrors divided clock", mism, 0);
    end
    cfg_mf_mode = 4'b1001;
    ref_in = 1'b1;
    step(2);
    chk("R11 ref mode high", int'(clk_out[4]), 1);
    chk("R11 ref mode driven", int'(clk_oe[4]), 1);
    chk("R11 input mode tri-state", int'(clk_oe[5]), 0);
    ref_in = 1'b0;
    step(1);
    chk("R11 ref mode low", int'(clk_out[4]), 0);
    chk("R11 cfg_err clean", int'(cfg_err), 0);
    cfg_mf_mode = 4'b1101;
    step(2);
    chk("R11 reserved mode tri-state", int'(clk_oe[5]), 0);
    chk("R11 reserved mode error", int'(cfg_err), 1);

    // R2 power-down on slot 2 ignored
    cfg_mf_mode = 4'b0010;
    cfg_role = roles(0, 0, 2, 0);
    pin_in = 4'b0000;
    step(20);
    chk("R2 cfg_err", int'(cfg_err), 1);
    chk("R2 no power-down", int'(low_power), 0);
    chk("R2 outputs driven", int'(clk_oe[0]), 1);

    // R3 duplicate role ignored
    cfg_mf_mode = 4'b0000;
    cfg_role = roles(1, 1, 0, 0);
    step(20);
    chk("R3 cfg_err", int'(cfg_err), 1);
    chk("R3 duplicate enable ignored", int'(clk_oe), 6'h3F);

    // R12 spread enable from slot 3
    cfg_mf_mode = 4'b1000;
    cfg_role = roles(0, 0, 0, 3);
    pin_in = 4'b0000;
    step(4);
    chk("R12 spread off", int'(spread_en), 0);
    pin_in = 4'b1000;
    step(4);
    chk("R12 spread on", int'(spread_en), 1);

    // random configurations against the model (R1 R3 R4)
    cfg_settle = 16'd3;
    for (int it = 0; it < 60; it++) begin
      logic [11:0] rl;
      for (int s = 0; s < 4; s++) rl[3*s +: 3] = 3'($urandom % 6);
      cfg_role = rl;
      cfg_mf_mode = 4'($urandom);
      cfg_div_a = 8'(2 + $urandom % 8);
      cfg_div_b = 8'(2 + $urandom % 8);
      pin_in = 4'($urandom);
      step(60);
      model(cfg_role, cfg_mf_mode, pin_in, e_err, e_oe, e_pdn, e_ss, e_sel);
      chk($sformatf("R1 R3 cfg_err it %0d", it), int'(cfg_err), int'(e_err));
      chk($sformatf("R4 spread it %0d", it), int'(spread_en), int'(e_ss));
      chk($sformatf("R7 low_power it %0d", it), int'(low_power), int'(!e_pdn));
      chk($sformatf("R6 oe it %0d", it), int'(clk_oe[0]), int'(e_pdn & e_oe));
      chk($sformatf("R11 oe5 it %0d", it), int'(clk_oe[4]),
          int'(e_pdn & e_oe & (cfg_mf_mode[1:0] < 2)));
      chk($sformatf("R10 sel it %0d", it), int'(div_sel), int'(e_sel));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule